// File: doc/BRIEF.md
# Smart Card Character Transmitter

This block sends character frames to a smart card over a single data line and produces the card's clock. Software writes a byte into a holding register. When the transmitter is enabled and the holding register is full, the byte moves into a shift register on a card-clock boundary. It is then sent as a start bit, the eight data bits least significant first, and an even parity bit. Every bit lasts a programmable number of card clock periods. A transmit-end flag rises after every frame. The interrupt request is the flag qualified by an enable bit, so software arms the enable only once the last byte of a burst has started, and only that final frame produces an interrupt.

The card clock is the system clock divided by an even ratio (twice a programmable half-period), which keeps a 50% duty cycle. When the clock enable is cleared, the period in progress runs to its end (high half, then low half) and then the clock stops. While stopped, the output holds a software-selected park level. A status output tells software that the clock has come to rest, so the part may enter standby within one card clock period of clearing the enable.

Top module: `smartcard_tx`

## Requirements
- R1: A frame is a 0 start bit, then data bits D0 through D7 (bit 0 first), then a parity bit equal to the XOR of D0..D7 (even parity). Each bit lasts exactly 2*halfDiv*etuCycles system clock cycles, and the start bit begins on a card clock period boundary.
- R2: txd is 1 whenever no frame is in progress. When txEn is 0 at a clock edge, txd is 1 from that edge on, and the frame in progress is dropped.
- R3: txEmpty is 1 after reset. A dataWr clears it at that clock edge. It becomes 1 again at the edge where the byte moves into the shift register, and the start bit appears at that same edge.
- R4: txEnd becomes 1 at the edge that ends the parity bit of every frame, with txd already back at 1. A dataWr or a 0-to-1 change of tendIntEn clears it.
- R5: tendIrq is 1 exactly when txEnd and tendIntEn are both 1, so a frame that ends while tendIntEn is 0 raises no request.
- R6: While running, cardClk has a period of 2*halfDiv system cycles, with halfDiv cycles high followed by halfDiv cycles low. A period starts with its high half.
- R7: When clkEn is cleared, the current period finishes both halves unshortened. clkIdle then rises no more than 2*halfDiv cycles after the clearing edge, and cardClk never stops in the middle of a high half.
- R8: While clkIdle is 1, cardClk equals clkParkLvl and follows changes to it. clkIdle stays 1 while clkEn stays 0.
- R9: After reset, txd=1, txEmpty=1, txEnd=0, tendIrq=0, clkIdle=1 and cardClk=clkParkLvl.
- R10: A dataWr while a byte is still waiting in the holding register replaces that byte, and only the newer byte is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| dataWr | input | 1 | Write strobe for the holding register |
| dataIn | input | 8 | Byte to write |
| txEn | input | 1 | Transmitter enable |
| clkEn | input | 1 | Card clock enable |
| clkParkLvl | input | 1 | Level of cardClk while stopped |
| tendIntEn | input | 1 | Transmit-end interrupt enable |
| halfDiv | input | DIV_W | System cycles per card clock half period (at least 1) |
| etuCycles | input | ETU_W | Card clock periods per bit (at least 1) |
| txd | output | 1 | Serial data line |
| cardClk | output | 1 | Card clock |
| clkIdle | output | 1 | Card clock has stopped |
| txEmpty | output | 1 | Holding register empty |
| txEnd | output | 1 | Transmit-end flag |
| tendIrq | output | 1 | Transmit-end interrupt request |

## Verification
Flag results from a write or an enable change appear at the next clock edge, so the bench drives inputs on falling edges and checks on the following falling edge. With halfDiv=2 and etuCycles=2, one bit lasts 8 cycles. The bench finds the start bit on the first falling-edge sample that shows txd low. It then reads each bit at its midpoint (4 cycles in, then every 8 cycles), and reads txEnd 4 cycles after the parity midpoint, which is the edge that ends the frame. Clock stop checks begin at the first sample of a high half. They count high and low samples until clkIdle is seen, so each half must span exactly halfDiv samples.

// File: rtl/smartcard_tx_pkg.sv
package smartcard_tx_pkg;
  localparam int FRAME_BITS = 10;
  localparam int BIT_W = $clog2(FRAME_BITS);

  typedef enum logic {TX_IDLE, TX_SHIFT} txState_t;

  typedef struct packed {
    logic load;
    logic shift;
    logic active;
  } dpStrobe_t;
endpackage

// File: rtl/smartcard_tx_clkgen.sv
module smartcard_tx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             clkEn,
  input  logic             clkParkLvl,
  input  logic [DIV_W-1:0] halfDiv,
  output logic             cardClk,
  output logic             clkIdle,
  output logic             tick
);
  logic             running;
  logic             phase;
  logic [DIV_W-1:0] divCnt;
  logic             halfEnd;

  assign halfEnd = (divCnt == halfDiv - DIV_W'(1));
  assign tick    = running && !phase && halfEnd;
  assign cardClk = running ? phase : clkParkLvl;
  assign clkIdle = !running;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      phase   <= 1'b0;
      divCnt  <= '0;
    end else if (!running) begin
      if (clkEn) begin
        running <= 1'b1;
        phase   <= 1'b1;
        divCnt  <= '0;
      end
    end else if (halfEnd) begin
      divCnt <= '0;
      // stop only once the low half of a period is complete
      if (!phase && !clkEn) running <= 1'b0;
      else                  phase   <= ~phase;
    end else begin
      divCnt <= divCnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/smartcard_tx_ctrl.sv
module smartcard_tx_ctrl
  import smartcard_tx_pkg::*;
#(
  parameter int ETU_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             tick,
  input  logic             dataWr,
  input  logic             txEn,
  input  logic             tendIntEn,
  input  logic [ETU_W-1:0] etuCycles,
  output dpStrobe_t        strobe,
  output logic             txEmpty,
  output logic             txEnd,
  output logic             tendIrq
);
  localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(FRAME_BITS - 1);

  txState_t         state;
  logic [ETU_W-1:0] etuCnt;
  logic [BIT_W-1:0] bitIdx;
  logic             enPrev;
  logic             loadNow, lastTick, shiftNow, frameDone;

  assign loadNow   = (state == TX_IDLE) && txEn && !txEmpty && tick;
  assign lastTick  = (state == TX_SHIFT) && txEn && tick &&
                     (etuCnt == etuCycles - ETU_W'(1));
  assign shiftNow  = lastTick && (bitIdx != LAST_BIT);
  assign frameDone = lastTick && (bitIdx == LAST_BIT);

  assign strobe.load   = loadNow;
  assign strobe.shift  = shiftNow;
  assign strobe.active = (state == TX_SHIFT);
  assign tendIrq       = txEnd && tendIntEn;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= TX_IDLE;
      etuCnt  <= '0;
      bitIdx  <= '0;
      enPrev  <= 1'b0;
      txEmpty <= 1'b1;
      txEnd   <= 1'b0;
    end else begin
      enPrev <= tendIntEn;

      if (!txEn)          state <= TX_IDLE;
      else if (loadNow)   state <= TX_SHIFT;
      else if (frameDone) state <= TX_IDLE;

      if (loadNow || !txEn)                etuCnt <= '0;
      else if (state == TX_SHIFT && tick)  etuCnt <= lastTick ? '0 : etuCnt + ETU_W'(1);

      if (loadNow)       bitIdx <= '0;
      else if (shiftNow) bitIdx <= bitIdx + BIT_W'(1);

      if (dataWr)       txEmpty <= 1'b0;
      else if (loadNow) txEmpty <= 1'b1;

      if (frameDone)                            txEnd <= 1'b1;
      else if (dataWr || (tendIntEn && !enPrev)) txEnd <= 1'b0;
    end
  end
endmodule

// File: rtl/smartcard_tx_dp.sv
module smartcard_tx_dp
  import smartcard_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       dataWr,
  input  logic [7:0] dataIn,
  input  dpStrobe_t  strobe,
  output logic       txd
);
  logic [7:0]            holdReg;
  logic [FRAME_BITS-1:0] shiftReg;

  assign txd = strobe.active ? shiftReg[0] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdReg  <= '0;
      shiftReg <= '1;
    end else begin
      if (dataWr) holdReg <= dataIn;
      if (strobe.load)       shiftReg <= {^holdReg, holdReg, 1'b0};
      else if (strobe.shift) shiftReg <= {1'b1, shiftReg[FRAME_BITS-1:1]};
    end
  end
endmodule

// File: rtl/smartcard_tx.sv
module smartcard_tx
  import smartcard_tx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int ETU_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             dataWr,
  input  logic [7:0]       dataIn,
  input  logic             txEn,
  input  logic             clkEn,
  input  logic             clkParkLvl,
  input  logic             tendIntEn,
  input  logic [DIV_W-1:0] halfDiv,
  input  logic [ETU_W-1:0] etuCycles,
  output logic             txd,
  output logic             cardClk,
  output logic             clkIdle,
  output logic             txEmpty,
  output logic             txEnd,
  output logic             tendIrq
);
  dpStrobe_t strobe;
  logic      tick;

  smartcard_tx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rstN(rstN), .clkEn(clkEn), .clkParkLvl(clkParkLvl),
    .halfDiv(halfDiv), .cardClk(cardClk), .clkIdle(clkIdle), .tick(tick)
  );

  smartcard_tx_ctrl #(.ETU_W(ETU_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .dataWr(dataWr), .txEn(txEn),
    .tendIntEn(tendIntEn), .etuCycles(etuCycles), .strobe(strobe),
    .txEmpty(txEmpty), .txEnd(txEnd), .tendIrq(tendIrq)
  );

  smartcard_tx_dp u_dp (
    .clk(clk), .rstN(rstN), .dataWr(dataWr), .dataIn(dataIn),
    .strobe(strobe), .txd(txd)
  );
endmodule

// File: rtl/smartcard_tx_chk.sv
module smartcard_tx_chk (
  input logic clk,
  input logic rstN,
  input logic dataWr,
  input logic txEn,
  input logic clkEn,
  input logic txd,
  input logic cardClk,
  input logic clkIdle,
  input logic txEmpty,
  input logic txEnd
);
  assert_disable_idle_R2: assert property (@(posedge clk) disable iff (!rstN)
    !txEn |=> txd);

  assert_write_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    dataWr |=> !txEmpty);

  assert_load_starts_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEmpty) |-> !txd);

  assert_end_line_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    $rose(txEnd) |-> txd);

  assert_stop_after_low_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(clkIdle) |-> !$past(cardClk));

  assert_keeps_running_R6: assert property (@(posedge clk) disable iff (!rstN)
    (clkEn && !clkIdle) |=> !clkIdle);

  assert_stays_parked_R8: assert property (@(posedge clk) disable iff (!rstN)
    (!clkEn && clkIdle) |=> clkIdle);
endmodule

bind smartcard_tx smartcard_tx_chk u_chk (.*);

// File: tb/smartcard_tx_bench.sv
`timescale 1ns/1ps
module smartcard_tx_bench;
  localparam int HALF = 2;
  localparam int ETU  = 2;
  localparam int BITC = 2 * HALF * ETU;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic dataWr = 1'b0;
  logic [7:0] dataIn = '0;
  logic txEn = 1'b0, clkEn = 1'b0, clkParkLvl = 1'b0, tendIntEn = 1'b0;
  logic [7:0] halfDiv = 8'(HALF);
  logic [7:0] etuCycles = 8'(ETU);
  logic txd, cardClk, clkIdle, txEmpty, txEnd, tendIrq;
  int checkCnt = 0, failCnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  smartcard_tx u_smartcard_tx (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic writeByte(input logic [7:0] b);
    @(negedge clk); dataWr = 1'b1; dataIn = b;
    @(negedge clk); dataWr = 1'b0;
  endtask

  task automatic captureFrame(input logic [7:0] b);
    int w = 0;
    while (txd && w < 400) begin @(negedge clk); w++; end
    check(!txd, "R1 start", txd, 0);
    for (int k = 0; k < 10; k++) begin
      logic e;
      repeat (k == 0 ? BITC / 2 : BITC) @(negedge clk);
      e = (k == 0) ? 1'b0 : (k == 9) ? ^b : b[k-1];
      check(txd == e, $sformatf("R1 bit%0d", k), txd, e);
    end
    repeat (BITC / 2) @(negedge clk);
    check(txEnd == 1'b1, "R4 end flag", txEnd, 1);
    check(txd == 1'b1, "R2 idle after frame", txd, 1);
  endtask

  task automatic testReset();
    check(txd == 1'b1, "R9 txd", txd, 1);
    check(txEmpty == 1'b1, "R9 txEmpty", txEmpty, 1);
    check(txEnd == 1'b0, "R9 txEnd", txEnd, 0);
    check(tendIrq == 1'b0, "R9 tendIrq", tendIrq, 0);
    check(clkIdle == 1'b1, "R9 clkIdle", clkIdle, 1);
    check(cardClk == clkParkLvl, "R9 cardClk", cardClk, clkParkLvl);
  endtask

  task automatic testClock();
    int hi = 0, lo = 0;
    @(negedge clk); clkEn = 1'b1;
    while (cardClk) @(negedge clk);
    while (!cardClk) @(negedge clk);
    while (cardClk) begin hi++; @(negedge clk); end
    while (!cardClk) begin lo++; @(negedge clk); end
    check(hi == HALF, "R6 high half", hi, HALF);
    check(lo == HALF, "R6 low half", lo, HALF);
  endtask

  task automatic testFrames();
    txEn = 1'b1;
    writeByte(8'hA5);
    check(txEmpty == 1'b0, "R3 cleared by write", txEmpty, 0);
    check(txEnd == 1'b0, "R4 cleared by write", txEnd, 0);
    captureFrame(8'hA5);
    check(txEmpty == 1'b1, "R3 set on load", txEmpty, 1);
    check(tendIrq == 1'b0, "R5 no irq when disabled", tendIrq, 0);
    writeByte(8'h00); captureFrame(8'h00);
    writeByte(8'hFF); captureFrame(8'hFF);
    writeByte(8'h3C); captureFrame(8'h3C);
  endtask

  task automatic testBurst();
    int w;
    writeByte(8'h5A);
    w = 0; while (!txEmpty && w < 100) begin @(negedge clk); w++; end
    writeByte(8'hC3);
    w = 0; while (!txEnd && w < 200) begin @(negedge clk); w++; end
    check(txEnd == 1'b1, "R4 first frame end", txEnd, 1);
    check(tendIrq == 1'b0, "R5 masked mid-burst", tendIrq, 0);
    w = 0; while (!txEmpty && w < 100) begin @(negedge clk); w++; end
    tendIntEn = 1'b1;
    @(negedge clk);
    check(txEnd == 1'b0, "R4 cleared by enable", txEnd, 0);
    check(tendIrq == 1'b0, "R5 no irq after arm", tendIrq, 0);
    w = 0; while (!txEnd && w < 200) begin @(negedge clk); w++; end
    check(tendIrq == 1'b1, "R5 irq on last frame", tendIrq, 1);
    tendIntEn = 1'b0;
    @(negedge clk);
    check(tendIrq == 1'b0 && txEnd == 1'b1, "R5 irq follows enable", tendIrq, 0);
  endtask

  task automatic testAbort();
    int w = 0;
    bit stayHigh = 1'b1;
    writeByte(8'h00);
    while (txd && w < 200) begin @(negedge clk); w++; end
    repeat (20) @(negedge clk);
    check(txd == 1'b0, "R2 mid-frame low", txd, 0);
    txEn = 1'b0;
    @(negedge clk);
    check(txd == 1'b1, "R2 disable idles line", txd, 1);
    txEn = 1'b1;
    for (int i = 0; i < 100; i++) begin @(negedge clk); if (!txd) stayHigh = 1'b0; end
    check(stayHigh, "R2 dropped frame not resumed", stayHigh, 1);
  endtask

  task automatic testReplace();
    txEn = 1'b0;
    writeByte(8'h11);
    writeByte(8'h96);
    txEn = 1'b1;
    captureFrame(8'h96);
    check(txEmpty == 1'b1, "R10 single frame", txEmpty, 1);
  endtask

  task automatic testStop(input logic park);
    int hi = 1, lo = 0, w = 0;
    bit parked = 1'b1;
    clkParkLvl = park;
    while (cardClk) @(negedge clk);
    while (!cardClk) @(negedge clk);
    clkEn = 1'b0;
    forever begin
      @(negedge clk); w++;
      if (clkIdle || w > 50) break;
      if (cardClk) hi++; else lo++;
    end
    check(hi == HALF, "R7 high half kept", hi, HALF);
    check(lo == HALF, "R7 low half kept", lo, HALF);
    check(w <= 2 * HALF, "R7 stop latency", w, 2 * HALF);
    for (int i = 0; i < 8; i++) begin @(negedge clk); if (cardClk != park) parked = 1'b0; end
    check(parked && clkIdle, "R8 park level", cardClk, park);
    clkParkLvl = ~park;
    @(negedge clk);
    check(cardClk == ~park, "R8 follows park bit", cardClk, ~park);
    clkParkLvl = park;
    clkEn = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testClock();
    testFrames();
    testBurst();
    testAbort();
    testReplace();
    testStop(1'b0);
    testStop(1'b1);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failCnt++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
      $finish;
    end
  end
endmodule